// File: doc/BRIEF.md
# Per-Input Virtual Channel Dispenser with Wing Bypass Selection

This unit sits at one input port of a network-on-chip router. When a packet header arrives, it names a logical channel. The unit binds that logical channel to one of four physical channels at this port and records the binding in a small table. Each table entry holds the physical channel and a write pointer. The pointer advances as flits of the packet are stored. When the tail flit leaves, the binding is dropped and the physical channel goes back to the free pool.

Channel 0 is the wing channel. A packet placed there is sent straight across the crossbar in one cycle, with no switch allocation. The bypass is granted only when the packet's output is free and this input is free. The output is free when the second-phase switch-arbitration request selected by the header's next-route direction is low. The input is free when this input did not win switch allocation in the previous cycle.

The other three channels are normal channels, split by message class for deadlock freedom. Channel 1 is shared by both classes. Channel 2 is reserved for requests and channel 3 for responses. A packet marked as at risk of deadlock goes to its class's reserved channel first. When the normal channels a packet may use are all taken, the wing channel is handed out anyway as an ordinary channel.

Top module: `vc_dispenser`

## Requirements
- R1: After reset, all four channels are free, `grant_valid`, `grant_fail` and `grant_wing` are 0, and every table entry reads back with `lk_valid` = 0.
- R2: A header with `hdr_dlk` = 0 arriving while channel 0 is free, with `sa2_req[hdr_dir]` = 0 and `sa_prev_win` = 0, is granted channel 0 with `grant_wing` = 1. The result appears in the cycle after the header is sampled.
- R3: Only bit `hdr_dir` of `sa2_req` takes part in the bypass decision. If that bit is 1, no bypass is given. Bits for other directions have no effect.
- R4: `sa_prev_win` = 1 prevents the bypass, whatever `sa2_req` holds.
- R5: Without a bypass, a packet gets the lowest-numbered free normal channel of its class. Requests (`hdr_class` = 0) try channel 1 and then channel 2. Responses (`hdr_class` = 1) try channel 1 and then channel 3.
- R6: When all normal channels of the packet's class are busy and channel 0 is free, channel 0 is granted with `grant_wing` = 0.
- R7: A packet with `hdr_dlk` = 1 never takes the bypass. It is granted its class's reserved channel (2 for requests, 3 for responses) if that channel is free, then channel 1, then channel 0 with `grant_wing` = 0.
- R8: When no channel the packet may use is free, `grant_fail` = 1 and `grant_valid` = 0, and neither the table nor the free pool changes.
- R9: A lookup of a logical ID returns that entry's valid bit, physical channel and write pointer one cycle later. A grant sets the pointer to 0. Each `flit_wr` to the entry adds 1 to the pointer, modulo 4 flit slots.
- R10: A `rel_valid` pulse for a bound logical ID clears the entry and frees its physical channel, so the next grant can use that channel again.
- R11: A request packet is never granted channel 3, and a response packet is never granted channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | New packet header present this cycle |
| hdr_logid | input | 2 | Logical channel ID carried in the header |
| hdr_class | input | 1 | Message class: 0 request, 1 response |
| hdr_dlk | input | 1 | Packet marked as at risk of deadlock |
| hdr_dir | input | 3 | Next-route output direction (0..4) |
| sa2_req | input | 5 | Second-phase switch-arbitration inputs, one per output |
| sa_prev_win | input | 1 | This input won switch allocation in the previous cycle |
| flit_wr | input | 1 | A flit was written into the buffer of `flit_logid` |
| flit_logid | input | 2 | Logical ID of the written flit |
| rel_valid | input | 1 | Tail flit of `rel_logid` has departed |
| rel_logid | input | 2 | Logical ID being released |
| lk_logid | input | 2 | Logical ID to look up |
| grant_valid | output | 1 | A channel was dispensed |
| grant_fail | output | 1 | Header could not be given any channel |
| grant_wing | output | 1 | Dispensed channel is a single-cycle bypass |
| grant_ch | output | 2 | Dispensed physical channel |
| lk_valid | output | 1 | Looked-up entry is bound |
| lk_ch | output | 2 | Looked-up physical channel |
| lk_tail | output | 2 | Looked-up write pointer |

## Verification
The dispenser is driven with headers under several conditions, and each one separates a different decision path:
- Fully idle port: shows that the bypass is granted at all.
- Arbitration request on the packet's own direction versus another direction: shows that the multiplexer keys on `hdr_dir`.
- Previous-win signal raised: isolates the input-side check.
- Occupancy climbing from empty to full, separately for each class: proves the ordering, the wing fallback, the class split and the failure case.
- Deadlock-marked headers on an idle port: show that reserved channels beat the bypass.
- Pointer increments past the wrap and release/reuse sequences: check the table through its lookup port.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int NCH     = 4;
  localparam int CH_W    = 2;
  localparam logic [CH_W-1:0] CH_WING   = 2'd0;
  localparam logic [CH_W-1:0] CH_SHARED = 2'd1;
  localparam logic [CH_W-1:0] CH_REQX   = 2'd2;
  localparam logic [CH_W-1:0] CH_RSPX   = 2'd3;
  typedef enum logic {CLS_REQ = 1'b0, CLS_RSP = 1'b1} msg_cls_e;
endpackage

// File: rtl/vcd_wing_flag.sv
module vcd_wing_flag #(
  parameter int NUM_DIRS = 5,
  parameter int DIR_W    = 3
) (
  input  logic [NUM_DIRS-1:0] sa2_req,
  input  logic [DIR_W-1:0]    dir,
  input  logic                sa_prev_win,
  output logic                wing_ok
);
  logic out_busy;
  always_comb begin
    out_busy = 1'b1;
    for (int d = 0; d < NUM_DIRS; d++)
      if (dir == DIR_W'(d)) out_busy = sa2_req[d];
  end
  assign wing_ok = !out_busy && !sa_prev_win;
endmodule

// File: rtl/vcd_tracker.sv
module vcd_tracker
  import vcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_en,
  input  logic [CH_W-1:0] alloc_ch,
  input  logic            free_en,
  input  logic [CH_W-1:0] free_ch,
  output logic [NCH-1:0]  busy
);
  logic [NCH-1:0] amask, fmask;
  always_comb begin
    amask = '0;
    fmask = '0;
    if (alloc_en) amask[alloc_ch] = 1'b1;
    if (free_en)  fmask[free_ch]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~fmask) | amask;
  end

  p_no_busy_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !busy[alloc_ch]);
  p_free_was_busy_r10: assert property (@(posedge clk) disable iff (rst)
    free_en |-> busy[free_ch]);
endmodule

// File: rtl/vcd_assigner.sv
module vcd_assigner
  import vcd_pkg::*;
(
  input  logic [NCH-1:0]  busy,
  input  logic            cls,
  input  logic            dlk,
  input  logic            wing_ok,
  output logic            pick_vld,
  output logic [CH_W-1:0] pick_ch,
  output logic            pick_wing
);
  logic [CH_W-1:0] excl;
  assign excl = (cls == CLS_RSP) ? CH_RSPX : CH_REQX;

  always_comb begin
    pick_vld  = 1'b1;
    pick_ch   = CH_WING;
    pick_wing = 1'b0;
    if (dlk) begin
      if      (!busy[excl])      pick_ch = excl;
      else if (!busy[CH_SHARED]) pick_ch = CH_SHARED;
      else if (!busy[CH_WING])   pick_ch = CH_WING;
      else                       pick_vld = 1'b0;
    end else begin
      if (wing_ok && !busy[CH_WING]) begin
        pick_ch   = CH_WING;
        pick_wing = 1'b1;
      end
      else if (!busy[CH_SHARED]) pick_ch = CH_SHARED;
      else if (!busy[excl])      pick_ch = excl;
      else if (!busy[CH_WING])   pick_ch = CH_WING;
      else                       pick_vld = 1'b0;
    end
  end
endmodule

// File: rtl/vcd_table.sv
module vcd_table
  import vcd_pkg::*;
#(
  parameter int LOG_W = 2,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LOG_W-1:0] wr_id,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic             fw_en,
  input  logic [LOG_W-1:0] fw_id,
  input  logic             rel_en,
  input  logic [LOG_W-1:0] rel_id,
  output logic             rel_hit,
  output logic [CH_W-1:0]  rel_ch,
  input  logic [LOG_W-1:0] rd_id,
  output logic             rd_vld,
  output logic [CH_W-1:0]  rd_ch,
  output logic [PTR_W-1:0] rd_tail
);
  localparam int NENT = 1 << LOG_W;

  logic [NENT-1:0]  vld_q;
  logic [CH_W-1:0]  ch_q   [NENT];
  logic [PTR_W-1:0] tail_q [NENT];

  assign rel_hit = rel_en && vld_q[rel_id];
  assign rel_ch  = ch_q[rel_id];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[e]  <= 1'b0;
        ch_q[e]   <= '0;
        tail_q[e] <= '0;
      end else if (wr_en && wr_id == LOG_W'(e)) begin
        vld_q[e]  <= 1'b1;
        ch_q[e]   <= wr_ch;
        tail_q[e] <= '0;
      end else begin
        if (rel_en && rel_id == LOG_W'(e)) vld_q[e] <= 1'b0;
        if (fw_en && fw_id == LOG_W'(e))   tail_q[e] <= tail_q[e] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_ch   <= '0;
      rd_tail <= '0;
    end else begin
      rd_vld  <= vld_q[rd_id];
      rd_ch   <= ch_q[rd_id];
      rd_tail <= tail_q[rd_id];
    end
  end

  p_tail_step_r9: assert property (@(posedge clk) disable iff (rst)
    (fw_en && !(wr_en && wr_id == fw_id)) |=>
      (tail_q[$past(fw_id)] == PTR_W'($past(tail_q[fw_id]) + 1'b1)));
endmodule

// File: rtl/vc_dispenser.sv
module vc_dispenser
  import vcd_pkg::*;
#(
  parameter int NUM_DIRS      = 5,
  parameter int DIR_W         = 3,
  parameter int LOG_W         = 2,
  parameter int FLITS_PER_CH  = 4,
  localparam int PTR_W        = $clog2(FLITS_PER_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_valid,
  input  logic [LOG_W-1:0]    hdr_logid,
  input  logic                hdr_class,
  input  logic                hdr_dlk,
  input  logic [DIR_W-1:0]    hdr_dir,
  input  logic [NUM_DIRS-1:0] sa2_req,
  input  logic                sa_prev_win,
  input  logic                flit_wr,
  input  logic [LOG_W-1:0]    flit_logid,
  input  logic                rel_valid,
  input  logic [LOG_W-1:0]    rel_logid,
  input  logic [LOG_W-1:0]    lk_logid,
  output logic                grant_valid,
  output logic                grant_fail,
  output logic                grant_wing,
  output logic [CH_W-1:0]     grant_ch,
  output logic                lk_valid,
  output logic [CH_W-1:0]     lk_ch,
  output logic [PTR_W-1:0]    lk_tail
);
  logic            wing_ok;
  logic [NCH-1:0]  busy;
  logic            pick_vld, pick_wing;
  logic [CH_W-1:0] pick_ch;
  logic            rel_hit;
  logic [CH_W-1:0] rel_ch;
  logic            alloc_en;

  vcd_wing_flag #(.NUM_DIRS(NUM_DIRS), .DIR_W(DIR_W)) u_flag (
    .sa2_req(sa2_req), .dir(hdr_dir), .sa_prev_win(sa_prev_win),
    .wing_ok(wing_ok));

  vcd_assigner u_asg (
    .busy(busy), .cls(hdr_class), .dlk(hdr_dlk), .wing_ok(wing_ok),
    .pick_vld(pick_vld), .pick_ch(pick_ch), .pick_wing(pick_wing));

  assign alloc_en = hdr_valid && pick_vld;

  vcd_tracker u_trk (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_ch(pick_ch),
    .free_en(rel_hit), .free_ch(rel_ch), .busy(busy));

  vcd_table #(.LOG_W(LOG_W), .PTR_W(PTR_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(alloc_en), .wr_id(hdr_logid), .wr_ch(pick_ch),
    .fw_en(flit_wr), .fw_id(flit_logid),
    .rel_en(rel_valid), .rel_id(rel_logid),
    .rel_hit(rel_hit), .rel_ch(rel_ch),
    .rd_id(lk_logid), .rd_vld(lk_valid), .rd_ch(lk_ch), .rd_tail(lk_tail));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_fail  <= 1'b0;
      grant_wing  <= 1'b0;
      grant_ch    <= '0;
    end else begin
      grant_valid <= alloc_en;
      grant_fail  <= hdr_valid && !pick_vld;
      grant_wing  <= alloc_en && pick_wing;
      grant_ch    <= pick_ch;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!grant_valid && !grant_fail));
  p_wing_on_ch0_r2: assert property (@(posedge clk) disable iff (rst)
    grant_wing |-> (grant_valid && grant_ch == CH_WING));
  p_fail_alone_r8: assert property (@(posedge clk) disable iff (rst)
    grant_fail |-> !grant_valid);
  p_class_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_ch == CH_RSPX) |-> $past(hdr_class) == CLS_RSP);
  p_class_req_r11: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_ch == CH_REQX) |-> $past(hdr_class) == CLS_REQ);
  p_dlk_no_wing_r7: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_dlk) |=> !grant_wing);
endmodule

// File: tb/vc_dispenser_test.sv
module vc_dispenser_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 0, hdr_class = 0, hdr_dlk = 0, sa_prev_win = 0;
  logic [1:0] hdr_logid = 0, flit_logid = 0, rel_logid = 0, lk_logid = 0;
  logic [2:0] hdr_dir = 0;
  logic [4:0] sa2_req = 0;
  logic flit_wr = 0, rel_valid = 0;
  logic grant_valid, grant_fail, grant_wing, lk_valid;
  logic [1:0] grant_ch, lk_ch, lk_tail;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  vc_dispenser uut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_logid(hdr_logid),
    .hdr_class(hdr_class), .hdr_dlk(hdr_dlk), .hdr_dir(hdr_dir),
    .sa2_req(sa2_req), .sa_prev_win(sa_prev_win), .flit_wr(flit_wr),
    .flit_logid(flit_logid), .rel_valid(rel_valid), .rel_logid(rel_logid),
    .lk_logid(lk_logid), .grant_valid(grant_valid), .grant_fail(grant_fail),
    .grant_wing(grant_wing), .grant_ch(grant_ch), .lk_valid(lk_valid),
    .lk_ch(lk_ch), .lk_tail(lk_tail));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present one header; outputs checked after the capturing edge
  task automatic hdr(input logic [1:0] id, input logic cls, input logic [2:0] dir,
                     input logic dlk, input int ok, input int ch, input int wing,
                     input string tag);
    @(negedge clk);
    hdr_valid = 1; hdr_logid = id; hdr_class = cls; hdr_dir = dir; hdr_dlk = dlk;
    @(negedge clk);
    hdr_valid = 0; hdr_dlk = 0;
    chk({tag, " valid"}, grant_valid, ok);
    chk({tag, " fail"}, grant_fail, ok ? 0 : 1);
    if (ok != 0) begin
      chk({tag, " ch"}, grant_ch, ch);
      chk({tag, " wing"}, grant_wing, wing);
    end
  endtask

  task automatic release_id(input logic [1:0] id);
    @(negedge clk); rel_valid = 1; rel_logid = id;
    @(negedge clk); rel_valid = 0;
  endtask

  task automatic lookup(input logic [1:0] id, input int v, input int ch,
                        input int tl, input string tag);
    @(negedge clk); lk_logid = id;
    @(negedge clk);
    chk({tag, " lk_valid"}, lk_valid, v);
    if (v != 0) begin
      chk({tag, " lk_ch"}, lk_ch, ch);
      chk({tag, " lk_tail"}, lk_tail, tl);
    end
  endtask

  task automatic release_all();
    for (int i = 0; i < 4; i++) release_id(2'(i));
  endtask

  task automatic t_reset();
    chk("R1 grant_valid", grant_valid, 0);
    chk("R1 grant_fail", grant_fail, 0);
    chk("R1 grant_wing", grant_wing, 0);
    for (int i = 0; i < 4; i++) lookup(2'(i), 0, 0, 0, "R1 entry");
  endtask

  task automatic t_wing();
    sa2_req = 0; sa_prev_win = 0;
    hdr(0, 0, 3'd2, 0, 1, 0, 1, "R2 idle bypass");
    release_all();
  endtask

  task automatic t_dir_mux();
    sa_prev_win = 0;
    sa2_req = 5'b00100;
    hdr(0, 0, 3'd2, 0, 1, 1, 0, "R3 own dir busy");
    release_all();
    sa2_req = 5'b11011;
    hdr(0, 0, 3'd2, 0, 1, 0, 1, "R3 other dirs busy");
    release_all();
    sa2_req = 0;
  endtask

  task automatic t_prev();
    sa2_req = 0; sa_prev_win = 1;
    hdr(1, 1, 3'd0, 0, 1, 1, 0, "R4 prev win");
    release_all();
    sa_prev_win = 0;
  endtask

  task automatic t_fill_req();
    sa_prev_win = 1;
    hdr(0, 0, 3'd1, 0, 1, 1, 0, "R5 req first");
    hdr(1, 0, 3'd1, 0, 1, 2, 0, "R5 req second");
    hdr(2, 0, 3'd1, 0, 1, 0, 0, "R6 req wing fallback");
    hdr(3, 0, 3'd1, 0, 0, 0, 0, "R8 req full");
    lookup(3, 0, 0, 0, "R8 no entry");
    sa_prev_win = 0;
    hdr(3, 1, 3'd1, 0, 1, 3, 0, "R11 rsp gets 3 not wing");
    release_all();
  endtask

  task automatic t_fill_rsp();
    sa_prev_win = 1;
    hdr(0, 1, 3'd4, 0, 1, 1, 0, "R5 rsp first");
    hdr(1, 1, 3'd4, 0, 1, 3, 0, "R5 rsp second");
    hdr(2, 1, 3'd4, 0, 1, 0, 0, "R6 rsp wing fallback");
    hdr(3, 1, 3'd4, 0, 0, 0, 0, "R11 rsp no ch2");
    sa_prev_win = 0;
    release_all();
  endtask

  task automatic t_dlk();
    sa2_req = 0; sa_prev_win = 0;
    hdr(0, 0, 3'd0, 1, 1, 2, 0, "R7 req reserved");
    hdr(1, 1, 3'd0, 1, 1, 3, 0, "R7 rsp reserved");
    hdr(2, 0, 3'd0, 1, 1, 1, 0, "R7 req shared next");
    hdr(3, 1, 3'd0, 1, 1, 0, 0, "R7 wing as normal");
    release_all();
  endtask

  task automatic t_table();
    sa_prev_win = 1;
    hdr(1, 0, 3'd3, 0, 1, 1, 0, "R9 bind");
    lookup(1, 1, 1, 0, "R9 fresh");
    @(negedge clk); flit_wr = 1; flit_logid = 1;
    repeat (5) @(negedge clk);
    flit_wr = 0;
    lookup(1, 1, 1, 1, "R9 wrap");
    release_id(1);
    lookup(1, 0, 0, 0, "R10 cleared");
    hdr(2, 0, 3'd3, 0, 1, 1, 0, "R10 reuse");
    release_all();
    sa_prev_win = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_wing();
    t_dir_mux();
    t_prev();
    t_fill_req();
    t_fill_rsp();
    t_dlk();
    t_table();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule